// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches one external pin and turns its activity into an interrupt request for the interrupt controller. The pin level first passes through a synchronizer. A 2-bit sense selector then decides how the level is read. In low-level mode the request follows the pin directly for as long as the pin is low, and nothing is latched. In the two edge modes a qualifying transition sets a pending flag, which stays set until the controller acknowledges it.

Software cannot read or write the pending flag. The only way to discard a stale edge is to pass through low-level mode, which clears the flag. Sensing always uses the observed pin level, so firmware that drives the pin from its own output buffer can raise the interrupt on purpose. A mask-enable input gates what reaches the controller. The flag still records edges while the mask is off.

Top module: `extint_sense_unit`

## Requirements
- R1: While reset is asserted and after its release, `irq_req` is 0, the pending flag is clear and the synchronizer holds the idle pin level (parameter `IDLE_LEVEL`, default 1), so no false edge is seen.
- R2: With `sense_sel` = 2'b00 (low level) and `mask_en` = 1, `irq_req` equals the inverted pin level delayed by `SYNC_STAGES` rising clock edges (default 2). It drops as soon as the synchronized pin is high, and no state is latched.
- R3: With `sense_sel` = 2'b10 (falling edge), a high-to-low transition of the synchronized pin sets the pending flag. With the mask on, `irq_req` rises `SYNC_STAGES`+1 edges after the pin falls and stays high after the pin returns high.
- R4: With `sense_sel` = 2'b11 (rising edge), a low-to-high transition of the synchronized pin sets the pending flag, with the same latency as R3.
- R5: A one-cycle `ack` pulse clears the pending flag at the next edge. If a qualifying edge arrives in the same cycle as `ack`, the edge wins and the flag stays set.
- R6: With `sense_sel` = 2'b01 (reserved), `irq_req` is 0 whatever the pin does, and any pending flag is cleared.
- R7: `irq_req` is 0 whenever `mask_en` is 0. Edges still set the pending flag while masked, so the request appears as soon as the mask is re-enabled.
- R8: Selecting low-level mode for one clock cycle clears a pending edge flag. After the sequence mask off, level mode, edge mode, mask on, no request is raised while the pin stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_lvl | input | 1 | Observed pin level, asynchronous to clk |
| sense_sel | input | 2 | Sense mode: 00 low, 01 reserved, 10 falling, 11 rising |
| mask_en | input | 1 | Passes the request to the controller when 1 |
| ack | input | 1 | Single-cycle acknowledge from the controller |
| irq_req | output | 1 | Interrupt request to the controller |

## Verification
A wrongly held or wrongly cleared pending flag shows up at `irq_req` in the first cycle the mask is on in an edge mode. A synchronizer of the wrong depth shifts the request by whole cycles, both for level sensing and for edges. The bench runs a behavioural model of the pin history and the flag alongside the design and compares the request on every clock. A latency error, a lost acknowledge priority or a stale flag that survives a pass through level mode therefore fails in the cycle where it first appears.

// File: rtl/extint_pkg.sv
package extint_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_RSVD = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_mode_e;

   function automatic logic is_edge_mode(sense_mode_e m);
      return m[1];
   endfunction
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int   STAGES    = 2,
   parameter logic RST_VALUE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_depth
      $error("extint_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VALUE;
            else        chain_q[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_VALUE;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/extint_edge_det.sv
module extint_edge_det #(
   parameter logic RST_VALUE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VALUE;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/extint_pend_flag.sv
module extint_pend_flag
   import extint_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  sense_mode_e mode,
   input  logic        rise,
   input  logic        fall,
   input  logic        ack,
   output logic        hit,
   output logic        flag_q
);
   logic flag_d;

   always_comb begin
      unique case (mode)
         SENSE_FALL: hit = fall;
         SENSE_RISE: hit = rise;
         default:    hit = 1'b0;
      endcase
   end

   always_comb begin
      if (!is_edge_mode(mode)) flag_d = 1'b0;
      else if (hit)            flag_d = 1'b1;
      else if (ack)            flag_d = 1'b0;
      else                     flag_d = flag_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end
endmodule

// File: rtl/extint_sense_unit.sv
module extint_sense_unit
   import extint_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_lvl,
   input  logic [1:0] sense_sel,
   input  logic       mask_en,
   input  logic       ack,
   output logic       irq_req
);
   sense_mode_e mode;
   logic        sync_lvl;
   logic        rise;
   logic        fall;
   logic        edge_hit;
   logic        flag_q;
   logic        raw_req;

   assign mode = sense_mode_e'(sense_sel);

   extint_sync #(
      .STAGES    (SYNC_STAGES),
      .RST_VALUE (IDLE_LEVEL)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_lvl),
      .q_sync  (sync_lvl)
   );

   extint_edge_det #(
      .RST_VALUE (IDLE_LEVEL)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (sync_lvl),
      .rise  (rise),
      .fall  (fall)
   );

   extint_pend_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode),
      .rise   (rise),
      .fall   (fall),
      .ack    (ack),
      .hit    (edge_hit),
      .flag_q (flag_q)
   );

   always_comb begin
      unique case (mode)
         SENSE_LOW:              raw_req = ~sync_lvl;
         SENSE_FALL, SENSE_RISE: raw_req = flag_q;
         default:                raw_req = 1'b0;
      endcase
   end

   assign irq_req = mask_en & raw_req;
endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] sense_sel,
   input logic       mask_en,
   input logic       ack,
   input logic       irq_req,
   input logic       sync_lvl,
   input logic       edge_hit,
   input logic       flag_q
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!flag_q && !irq_req));

   // R2
   level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_sel == 2'b00 && mask_en) |-> (irq_req == !sync_lvl));

   // R3
   edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> flag_q);

   // R5
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !edge_hit) |=> !flag_q);

   // R6
   reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_sel == 2'b01) |-> !irq_req);

   // R7
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_en |-> !irq_req);

   // R8
   level_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_sel[1] == 1'b0) |=> !flag_q);
endmodule

bind extint_sense_unit extint_sense_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sense_sel (sense_sel),
   .mask_en   (mask_en),
   .ack       (ack),
   .irq_req   (irq_req),
   .sync_lvl  (sync_lvl),
   .edge_hit  (edge_hit),
   .flag_q    (flag_q)
);

// File: tb/extint_sense_unit_test.sv
module extint_sense_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int STAGES     = 2;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin   = 1'b1;
   logic       mask  = 1'b0;
   logic       ack   = 1'b0;
   logic [1:0] mode  = 2'b00;
   logic       req;

   int    n_chk  = 0;
   int    n_fail = 0;
   string phase  = "R1";

   bit hist [0:STAGES];
   bit m_flag = 1'b0;
   bit cur, prv, hit;

   always #(CLK_PERIOD/2) clk = ~clk;

   extint_sense_unit #(.SYNC_STAGES(STAGES), .IDLE_LEVEL(1'b1)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_lvl   (pin),
      .sense_sel (mode),
      .mask_en   (mask),
      .ack       (ack),
      .irq_req   (req)
   );

   initial for (int i = 0; i <= STAGES; i++) hist[i] = 1'b1;

   // behavioural reference: pin history plus pending flag
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i <= STAGES; i++) hist[i] = 1'b1;
         m_flag = 1'b0;
      end else begin
         cur = hist[STAGES-1];
         prv = hist[STAGES];
         hit = (mode == 2'b10 && prv && !cur) || (mode == 2'b11 && !prv && cur);
         if (mode[1] == 1'b0) m_flag = 1'b0;
         else if (hit)        m_flag = 1'b1;
         else if (ack)        m_flag = 1'b0;
         for (int i = STAGES; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = pin;
      end
   end

   function automatic bit expected();
      if (!mask) return 1'b0;
      case (mode)
         2'b00:        return !hist[STAGES-1];
         2'b10, 2'b11: return m_flag;
         default:      return 1'b0;
      endcase
   endfunction

   task automatic check();
      bit e;
      e = expected();
      n_chk++;
      if (req !== e) begin
         n_fail++;
         $display("FAIL %s t=%0t irq_req=%b expected=%b", phase, $time, req, e);
      end
   endtask

   task automatic step(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check();
      end
   endtask

   initial begin
      #(CLK_PERIOD*20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R1: reset state
      phase = "R1";
      step(3);
      rst_n = 1'b1;
      step(3);

      // R2: level sensing, no latching
      phase = "R2";
      mode = 2'b00; mask = 1'b1;
      step(1);
      pin = 1'b0; step(4);
      pin = 1'b1; step(4);
      pin = 1'b0; step(1);
      pin = 1'b1; step(4);

      // R3: falling edge latched
      phase = "R3";
      mode = 2'b10; step(2);
      pin = 1'b0; step(5);
      pin = 1'b1; step(4);

      // R5: acknowledge clears
      phase = "R5";
      ack = 1'b1; step(1);
      ack = 1'b0; step(3);

      // R4: rising edge latched
      phase = "R4";
      mode = 2'b11; pin = 1'b0; step(4);
      ack = 1'b1; step(1);
      ack = 1'b0; step(1);
      pin = 1'b1; step(5);
      ack = 1'b1; step(1);
      ack = 1'b0; step(2);

      // R5: edge in the acknowledge cycle wins
      phase = "R5";
      pin = 1'b0; step(4);
      pin = 1'b1; step(2);
      ack = 1'b1; step(1);
      ack = 1'b0; step(3);

      // R6: reserved mode quiet and flushes the flag
      phase = "R6";
      mode = 2'b01; step(2);
      pin = 1'b0; step(4);
      pin = 1'b1; step(4);
      mode = 2'b11; step(3);

      // R7: masked edge still recorded
      phase = "R7";
      mask = 1'b0; mode = 2'b10;
      pin = 1'b0; step(5);
      pin = 1'b1; step(3);
      mask = 1'b1; step(2);
      ack = 1'b1; step(1);
      ack = 1'b0; step(1);

      // R8: stale flag discarded via level mode
      phase = "R8";
      mask = 1'b0; pin = 1'b0; step(4);
      pin = 1'b1; step(4);
      mode = 2'b00; step(1);
      mode = 2'b10; step(1);
      mask = 1'b1; step(4);
      pin = 1'b0; step(5);
      pin = 1'b1; step(3);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule